// File: doc/BRIEF.md
# ADC Conversion Start Controller

This block holds the control register of a successive-approximation converter and decides when a conversion begins. Software writes one 8-bit register that enables the converter, picks a track mode and selects the start source: a software write, one of four timer overflow pulses, or an external convert-start pin. The block then runs an optional tracking phase, issues a one-cycle start pulse to the SAR engine and waits for that engine's done input. When the conversion finishes it sets a completion flag.

Two track modes exist. In normal mode the input is tracked whenever the converter is enabled and idle, and a trigger starts conversion at once. In low-power mode a timer or software trigger first opens a tracking window of a fixed number of SAR clock ticks. With the pin source, tracking follows the pin: it runs while the pin is low, and conversion starts on the pin's rising edge. A window-compare match input is latched into a second flag. The interrupt request is the OR of the two flags. SAR clock ticks arrive as a single-cycle enable in the system clock domain. The pin is synchronized with two flops.

Top module: `adc_start_ctrl`

## Requirements
- R1: After reset `ctrl_q` reads 0. Its fields, from bit 7 down, are: enable (7), track mode (6, 1 = low power), completion flag (5), busy (4), window flag (3) and start select (2:0).
- R2: Start select values map as follows: 0 = software, 1 = `tmr_ovf[0]`, 2 = `tmr_ovf[2]`, 3 = `tmr_ovf[1]`, 4 = external pin rising edge, 5 = `tmr_ovf[3]`. Values 6 and 7 start nothing.
- R3: A register write starts a conversion only when the written data has bit 7 = 1, bit 4 = 1 and bits 2:0 = 0. A write with bit 4 = 0 starts nothing.
- R4: In normal track mode a trigger accepted at a clock edge sets busy and raises `conv_start` for exactly one cycle, both after that same edge.
- R5: In low-power mode with a software or timer source, a trigger starts a tracking phase. `conv_start` rises after the edge that samples the third `sar_tick` of that phase.
- R6: `cnv_pin` passes through a two-flop synchronizer before rising-edge detection. With select 4 in low-power mode, `tracking` is high while idle and the synchronized pin is low, and the rising edge starts conversion directly.
- R7: In normal mode `tracking` equals enable AND NOT busy. In low-power mode it is high during the tracking phase, and otherwise only as described in R6.
- R8: `conv_done` during conversion clears busy and sets the completion flag at the same edge. The flag stays set until a write clears it. A same-cycle write of 0 loses to the setting event.
- R9: `win_match` sets the window flag, which stays set until a write of 0 clears it. The setting event wins over a same-cycle clear.
- R10: Triggers are ignored while busy, and hardware triggers are ignored while enable is 0.
- R11: A write with bit 7 = 0 stops any tracking or conversion at once. Busy clears, and the completion flag is not set.
- R12: `irq` is the OR of the completion flag and the window flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| ctrl_q | output | 8 | Register readback |
| tmr_ovf | input | 4 | Timer overflow pulses, index = timer number |
| cnv_pin | input | 1 | External convert-start pin (asynchronous) |
| sar_tick | input | 1 | One-cycle SAR clock enable |
| conv_done | input | 1 | SAR engine reports end of conversion |
| win_match | input | 1 | Window comparator match |
| conv_start | output | 1 | One-cycle pulse that starts the SAR engine |
| tracking | output | 1 | Sample-and-hold tracking enable |
| irq | output | 1 | Interrupt request |

## Verification
The completion event and a software write to the register can land in the same cycle. The same holds for a window match and a write. The bench forces both collisions: it writes the flag bits as 0 in the cycle where `conv_done` or `win_match` is high, and it expects the flag to read 1 afterwards. A write that clears enable in the same cycle as `conv_done` is also provoked, and the expected result is no completion flag. A long random phase then mixes writes, timer pulses, pin toggles and done pulses. It is judged cycle by cycle against a behavioural reference model.

// File: rtl/adc_start_ctrl.sv
module adc_start_ctrl #(
  parameter int TRK_TICKS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] ctrl_q,
  input  logic [3:0] tmr_ovf,
  input  logic       cnv_pin,
  input  logic       sar_tick,
  input  logic       conv_done,
  input  logic       win_match,
  output logic       conv_start,
  output logic       tracking,
  output logic       irq
);
  localparam int CW = (TRK_TICKS > 1) ? $clog2(TRK_TICKS) : 1;
  localparam logic [2:0] SEL_PIN = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_TRACK, S_CONV} st_t;

  st_t         st_q;
  logic [CW-1:0] cnt_q;
  logic        en_q, tm_q, done_q, win_q, cs_q;
  logic [2:0]  sel_q;
  logic [2:0]  pin_sh;
  logic        hw_src;

  wire busy     = (st_q != S_IDLE);
  wire pin_s    = pin_sh[1];
  wire pin_rise = pin_sh[1] & ~pin_sh[2];

  always_comb begin
    case (sel_q)
      3'd1:    hw_src = tmr_ovf[0];
      3'd2:    hw_src = tmr_ovf[2];
      3'd3:    hw_src = tmr_ovf[1];
      3'd4:    hw_src = pin_rise;
      3'd5:    hw_src = tmr_ovf[3];
      default: hw_src = 1'b0;
    endcase
  end

  wire abort     = wr_en & ~wr_data[7];
  wire sw_trig   = wr_en & wr_data[7] & wr_data[4] & (wr_data[2:0] == 3'd0);
  wire hw_trig   = en_q & hw_src;
  wire trig      = ~busy & ~abort & (sw_trig | hw_trig);
  wire eff_tm    = wr_en ? wr_data[6] : tm_q;
  wire pin_direct = hw_trig & (sel_q == SEL_PIN);
  wire go_track  = trig & eff_tm & ~pin_direct;
  wire go_conv   = trig & ~go_track;
  wire trk_end   = (st_q == S_TRACK) & sar_tick & (cnt_q == CW'(TRK_TICKS - 1)) & ~abort;
  wire done_evt  = (st_q == S_CONV) & conv_done & ~abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_sh <= '0;
    else        pin_sh <= {pin_sh[1:0], cnv_pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      tm_q  <= 1'b0;
      sel_q <= 3'd0;
    end else if (wr_en) begin
      en_q  <= wr_data[7];
      tm_q  <= wr_data[6];
      sel_q <= wr_data[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      win_q  <= 1'b0;
    end else begin
      done_q <= (wr_en ? wr_data[5] : done_q) | done_evt;
      win_q  <= (wr_en ? wr_data[3] : win_q) | win_match;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      cs_q  <= 1'b0;
    end else begin
      cs_q <= go_conv | trk_end;
      if (abort) begin
        st_q <= S_IDLE;
      end else begin
        case (st_q)
          S_IDLE: begin
            cnt_q <= '0;
            if (go_track)     st_q <= S_TRACK;
            else if (go_conv) st_q <= S_CONV;
          end
          S_TRACK: begin
            if (trk_end)       st_q <= S_CONV;
            else if (sar_tick) cnt_q <= cnt_q + 1'b1;
          end
          S_CONV:  if (conv_done) st_q <= S_IDLE;
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  assign ctrl_q     = {en_q, tm_q, done_q, busy, win_q, sel_q};
  assign conv_start = cs_q;
  assign tracking   = en_q & ((st_q == S_TRACK) |
                      ((st_q == S_IDLE) & (~tm_q | ((sel_q == SEL_PIN) & ~pin_s))));
  assign irq        = done_q | win_q;

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R5
  track_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_TRACK) |-> (cnt_q < CW'(TRK_TICKS)));
  // R8
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (ctrl_q[5] && !ctrl_q[4]));
  // R9
  win_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_match |=> ctrl_q[3]);
  // R10
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[7] |-> !ctrl_q[4]);
  // R11
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[7]) |=> (!ctrl_q[4] && !conv_start));
endmodule

// File: tb/adc_start_ctrl_tb.sv
module adc_start_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] ctrl_q;
  logic [3:0] tmr_ovf = 0;
  logic       cnv_pin = 0, sar_tick = 0, conv_done = 0, win_match = 0;
  logic       conv_start, tracking, irq;

  int total = 0, bad = 0;
  bit chk_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_start_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ctrl_q(ctrl_q),
    .tmr_ovf(tmr_ovf), .cnv_pin(cnv_pin), .sar_tick(sar_tick), .conv_done(conv_done),
    .win_match(win_match), .conv_start(conv_start), .tracking(tracking), .irq(irq));

  // reference model: phase 0 idle, 1 tracking window, 2 converting
  int  m_phase = 0, m_ticks = 0;
  bit  m_en = 0, m_tm = 0, m_done = 0, m_win = 0, m_cs = 0;
  int  m_sel = 0;
  bit  pinq[$] = '{0, 0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_ticks = 0; m_en = 0; m_tm = 0; m_done = 0; m_win = 0;
      m_cs = 0; m_sel = 0; pinq = '{0, 0, 0};
    end else begin
      bit rise, hw, sw, stop, fire, lp, direct, fin;
      rise = pinq[1] && !pinq[2];
      hw = 0;
      if (m_en) begin
        if (m_sel == 1) hw = tmr_ovf[0];
        if (m_sel == 2) hw = tmr_ovf[2];
        if (m_sel == 3) hw = tmr_ovf[1];
        if (m_sel == 5) hw = tmr_ovf[3];
        if (m_sel == 4) hw = rise;
      end
      stop = wr_en && !wr_data[7];
      sw = wr_en && wr_data[7] && wr_data[4] && wr_data[2:0] == 0;
      fire = (m_phase == 0) && !stop && (sw || hw);
      lp = wr_en ? wr_data[6] : m_tm;
      direct = hw && m_sel == 4;
      fin = 0;
      m_cs = 0;
      if (stop) m_phase = 0;
      else if (m_phase == 0) begin
        m_ticks = 0;
        if (fire && lp && !direct) m_phase = 1;
        else if (fire) begin m_phase = 2; m_cs = 1; end
      end else if (m_phase == 1) begin
        if (sar_tick) begin
          m_ticks++;
          if (m_ticks == 3) begin m_phase = 2; m_cs = 1; end
        end
      end else if (conv_done) begin
        m_phase = 0; fin = 1;
      end
      if (wr_en) begin
        m_en = wr_data[7]; m_tm = wr_data[6]; m_sel = wr_data[2:0];
        m_done = wr_data[5]; m_win = wr_data[3];
      end
      if (fin) m_done = 1;
      if (win_match) m_win = 1;
      pinq.push_front(cnv_pin);
      void'(pinq.pop_back());
    end
  end

  task automatic cmp(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit m_track();
    if (!m_en) return 0;
    if (m_phase == 1) return 1;
    if (m_phase != 0) return 0;
    return !m_tm || (m_sel == 4 && !pinq[1]);
  endfunction

  always @(negedge clk) if (chk_on) begin
    cmp("R1 enable", ctrl_q[7], m_en);
    cmp("R1 mode", ctrl_q[6], m_tm);
    cmp("R1 select", ctrl_q[2:0], m_sel);
    cmp("R10 busy", ctrl_q[4], m_phase != 0);
    cmp("R8 done flag", ctrl_q[5], m_done);
    cmp("R9 window flag", ctrl_q[3], m_win);
    cmp("R4 conv_start", conv_start, m_cs);
    cmp("R7 tracking", tracking, m_track());
    cmp("R12 irq", irq, m_done || m_win);
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1; wr_data = d; step(); wr_en = 0;
  endtask

  task automatic pulse_done();
    conv_done = 1; step(); conv_done = 0;
  endtask

  task automatic ticks(int n);
    repeat (n) begin sar_tick = 1; step(); sar_tick = 0; step(); end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step();
    chk_on = 1;
    cmp("R1 reset value", ctrl_q, 0);

    // R3: busy bit written 0 starts nothing
    wr(8'h80); step();
    cmp("R3 write without busy", ctrl_q[4], 0);
    // R4 software start, normal mode
    wr(8'h90);
    cmp("R4 start pulse", conv_start, 1);
    step(3); pulse_done();
    cmp("R8 completion", ctrl_q[5], 1);
    wr(8'h80);
    // R8 collision: done and clear in same cycle
    wr(8'h90); step(2);
    wr_en = 1; wr_data = 8'h80; conv_done = 1; step(); wr_en = 0; conv_done = 0;
    cmp("R8 set beats clear", ctrl_q[5], 1);
    // R9 collision
    wr_en = 1; wr_data = 8'h80; win_match = 1; step(); wr_en = 0; win_match = 0;
    cmp("R9 set beats clear", ctrl_q[3], 1);
    cmp("R12 irq", irq, 1);
    wr(8'h80);
    // R2 timer sources
    for (int s = 1; s < 8; s++) begin
      if (s == 4) continue;
      wr(8'h80 | s[7:0]);
      for (int t = 0; t < 4; t++) begin
        tmr_ovf = 4'b1 << t; step(); tmr_ovf = 0; step();
        if (ctrl_q[4]) begin pulse_done(); step(); end
      end
    end
    // R2 reserved codes with every source active
    wr(8'h86); tmr_ovf = 4'hF; cnv_pin = 1; step(2); tmr_ovf = 0; cnv_pin = 0; step(3);
    cmp("R2 reserved select", ctrl_q[4], 0);
    // R5 low-power software start
    wr(8'hC0); wr(8'hD0); step(2); ticks(2);
    cmp("R5 still tracking", tracking, 1);
    sar_tick = 1; step(); sar_tick = 0;
    cmp("R5 start after third tick", conv_start, 1);
    step(); pulse_done();
    // R6 pin, normal then low power
    wr(8'h84); cnv_pin = 1; step(4); pulse_done(); cnv_pin = 0; step(3);
    wr(8'hC4); step(3);
    cmp("R6 tracks while pin low", tracking, 1);
    cnv_pin = 1; step(3);
    cmp("R6 rising edge converts", ctrl_q[4], 1);
    pulse_done(); cnv_pin = 0; step(3);
    // R10 disabled and busy triggers
    wr(8'h01); tmr_ovf = 4'hF; step(2); tmr_ovf = 0;
    cmp("R10 disabled trigger", ctrl_q[4], 0);
    wr(8'h81); tmr_ovf = 1; step(); tmr_ovf = 1; step(); tmr_ovf = 0; step();
    // R11 abort with same-cycle done
    wr_en = 1; wr_data = 8'h00; conv_done = 1; step(); wr_en = 0; conv_done = 0;
    cmp("R11 abort busy", ctrl_q[4], 0);
    cmp("R11 abort no flag", ctrl_q[5], 0);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      wr_en = ($urandom_range(0, 15) == 0);
      wr_data = $urandom_range(0, 255);
      if (wr_en && $urandom_range(0, 3) != 0) wr_data[7] = 1;
      tmr_ovf = ($urandom_range(0, 5) == 0) ? 4'($urandom_range(0, 15)) : 4'h0;
      if ($urandom_range(0, 9) == 0) cnv_pin = ~cnv_pin;
      sar_tick = $urandom_range(0, 1);
      conv_done = ($urandom_range(0, 6) == 0);
      win_match = ($urandom_range(0, 40) == 0);
      step();
    end
    wr_en = 0; tmr_ovf = 0; sar_tick = 0; conv_done = 0; win_match = 0;
    step(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule